// File: doc/BRIEF.md
# Burst-Length SPI Master

This block is an SPI master that shifts a programmable number of bits, from 1 to 4096, as one unbroken burst with chip select held low from the first bit to the last. The bit count does not have to be a multiple of the 32-bit word size. Software, or a neighbouring block, loads transmit words into an 8-deep TX FIFO, sets the burst length and the clock divider, and pulses `start`. Received bits are packed into 32-bit words and placed into an 8-deep RX FIFO, which is read through a show-ahead pop port.

When the burst length is not a whole number of words, the partial word goes out first. It is taken from the low bits of the first FIFO word. All later words are full 32-bit words, sent MSB first. If the TX FIFO runs dry in the middle of a burst, the master does not end the burst. It parks SCLK low, keeps chip select asserted, and carries on as soon as another word is pushed. No stray SCLK edges are produced at word boundaries, during a stall, or between bursts. The clock runs in mode 0: SCLK idles low, the slave's MISO is sampled on the rising edge, and MOSI changes after the falling edge.

Top module: `spi_burst_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk`, `busy` and `done` are 0, `tx_empty` and `rx_empty` are 1, and `tx_full` and `rx_full` are 0.
- R2: A `start` pulse while idle captures `burst_len`, which holds the bit count minus one, and `clk_div`. One clock later `cs_n` is 0 and `busy` is 1. A `start` pulse while busy is ignored.
- R3: SCLK idles low. Within a word, consecutive SCLK rising edges are 2*(clk_div+1) clock cycles apart. Across a word boundary the gap is one cycle longer. MISO is sampled at each rising edge.
- R4: A burst produces exactly burst_len+1 SCLK rising edges, and `cs_n` stays low during all of them.
- R5: The first FIFO word supplies (burst_len mod 32)+1 bits, taken from bit burst_len[4:0] down to bit 0. Each later word supplies bits 31 down to 0. MOSI holds the current bit at every rising edge.
- R6: For bit counts of the form 32n+1, the first word contributes only its bit 0, and all of the following 32n bits come out correctly.
- R7: If the TX FIFO is empty when the next word is needed, SCLK stays low and `cs_n` stays low with no extra edges. Shifting resumes after a word is pushed.
- R8: Received bits are shifted MSB first into 32-bit words counted from the first bit of the burst. The final partial word is right-aligned, with zeros above it.
- R9: Each FIFO holds 8 words and flags full and empty. A push into a full TX FIFO and a pop from an empty RX FIFO have no effect. `rx_data` shows the oldest word.
- R10: `done` pulses for one cycle in the cycle where `cs_n` returns high, and `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_len | input | 12 | Burst bit count minus one, sampled at start |
| clk_div | input | 8 | SCLK half period minus one, in clock cycles |
| start | input | 1 | Begin a burst (single-cycle pulse) |
| tx_push | input | 1 | Write `tx_data` into the TX FIFO |
| tx_data | input | 32 | Transmit word |
| tx_full | output | 1 | TX FIFO full |
| tx_empty | output | 1 | TX FIFO empty |
| rx_pop | input | 1 | Remove the oldest RX word |
| rx_data | output | 32 | Oldest RX word |
| rx_full | output | 1 | RX FIFO full |
| rx_empty | output | 1 | RX FIFO empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
`cs_n` and `busy` change one clock after the edge that samples `start`. Every SCLK rising edge arrives 2*(clk_div+1) cycles after the previous one, or 2*(clk_div+1)+1 cycles after it when a new word begins. `done` appears in the same cycle that `cs_n` rises. Received words can be popped from the cycle after their last bit's rising edge. The bench samples all outputs on the falling clock edge. It detects an SCLK rise by comparing against the value seen at the previous falling edge, measures the gap in cycles against the expected spacing, and pops the expected MOSI bit for that edge from the scoreboard queue. It then advances the slave's MISO bit well before the next rising edge.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int LEN_W = 12,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             start,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_full,
  output logic             tx_empty,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_data,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int BW = $clog2(DW);
  localparam int LW = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOW, S_HIGH} st_t;
  st_t st;

  logic [LEN_W-1:0] len_m1;
  logic [DIV_W-1:0] div_r, cnt;
  logic [LW-1:0]    left;
  logic [BW-1:0]    bidx, rxn;
  logic [DW-1:0]    sreg, rx_sh;
  logic             first, sclk_r, done_r;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire          rise        = (st == S_LOW) && (cnt == div_r);
  wire          rx_word_end = (rxn == BW'(DW-1)) || (left == LW'(1));
  wire [DW-1:0] rx_din      = {rx_sh[DW-2:0], miso};
  wire          tx_we       = tx_push && !tx_full;
  wire          tx_re       = (st == S_FETCH) && !tx_empty;
  wire          rx_we       = rise && rx_word_end && !rx_full;
  wire          rx_re       = rx_pop && !rx_empty;

  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign rx_data  = rx_mem[rx_rp];
  assign busy     = st != S_IDLE;
  assign cs_n     = !busy;
  assign sclk     = sclk_r;
  assign mosi     = busy ? sreg[bidx] : 1'b0;
  assign done     = done_r;

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[tx_wp] <= tx_data;
    if (rx_we) rx_mem[rx_wp] <= rx_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_we) tx_wp <= tx_wp + 1'b1;
      if (tx_re) tx_rp <= tx_rp + 1'b1;
      if (tx_we && !tx_re) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_we && tx_re) tx_cnt <= tx_cnt - 1'b1;
      if (rx_we) rx_wp <= rx_wp + 1'b1;
      if (rx_re) rx_rp <= rx_rp + 1'b1;
      if (rx_we && !rx_re) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_we && rx_re) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; len_m1 <= '0; div_r <= '0; cnt <= '0; left <= '0;
      bidx <= '0; rxn <= '0; sreg <= '0; rx_sh <= '0;
      first <= 1'b0; sclk_r <= 1'b0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          len_m1 <= burst_len;
          div_r  <= clk_div;
          left   <= {1'b0, burst_len} + LW'(1);
          first  <= 1'b1;
          rxn    <= '0;
          rx_sh  <= '0;
          st     <= S_FETCH;
        end
        S_FETCH: if (!tx_empty) begin
          sreg  <= tx_mem[tx_rp];
          bidx  <= first ? len_m1[BW-1:0] : BW'(DW-1);
          first <= 1'b0;
          cnt   <= '0;
          st    <= S_LOW;
        end
        S_LOW: if (rise) begin
          sclk_r <= 1'b1;
          cnt    <= '0;
          rx_sh  <= rx_word_end ? '0 : rx_din;
          rxn    <= rx_word_end ? '0 : rxn + 1'b1;
          st     <= S_HIGH;
        end else cnt <= cnt + 1'b1;
        S_HIGH: if (cnt == div_r) begin
          sclk_r <= 1'b0;
          cnt    <= '0;
          left   <= left - LW'(1);
          if (left == LW'(1)) begin
            st     <= S_IDLE;
            done_r <= 1'b1;
          end else if (bidx == '0) st <= S_FETCH;
          else begin
            bidx <= bidx - 1'b1;
            st   <= S_LOW;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  sclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_FETCH) |-> !sclk_r);
  // R2
  start_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cs_n) |=> !cs_n);
  // R4
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_r) |-> (left == $past(left) - LW'(1)));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && tx_empty) |=> (!sclk_r && !cs_n));
  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !sclk_r && $past(!cs_n)));
  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] burst_len = '0;
  logic [7:0]  clk_div = '0;
  logic        start = 1'b0, tx_push = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic [31:0] tx_data = '0, rx_data;
  logic        tx_full, tx_empty, rx_full, rx_empty, sclk, mosi, cs_n, busy, done;

  spi_burst_master u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int  vectors = 0, errs = 0;
  bit  exp_mosi[$];
  logic [31:0] exp_rx[$];
  bit  slv[4096];
  int  tot_rise = 0, base = 0, cyc = 0, last_cyc = 0;
  int  cur_fc = 1, cur_div = 0;
  bit  chk_per = 1'b0, sclk_q = 1'b0;
  string cur_tag = "R5";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: detect SCLK rises, score MOSI and spacing, drive slave MISO
  always @(negedge clk) begin
    int k, exp_gap;
    cyc++;
    if (sclk && !sclk_q) begin
      k = tot_rise - base;
      chk(!cs_n, "R4", {31'd0, cs_n}, 32'd0);
      if (exp_mosi.size() == 0) chk(1'b0, "R4", 32'd1, 32'd0);
      else chk(mosi == exp_mosi.pop_front(), cur_tag, {31'd0, mosi}, {31'd0, ~mosi});
      if (chk_per && k > 0) begin
        exp_gap = 2 * (cur_div + 1) + ((k >= cur_fc && (k - cur_fc) % 32 == 0) ? 1 : 0);
        chk(cyc - last_cyc == exp_gap, "R3", cyc - last_cyc, exp_gap);
      end
      last_cyc = cyc;
      tot_rise++;
    end
    sclk_q = sclk;
    miso = slv[(tot_rise - base) & 4095];
  end

  task automatic push_tx(input logic [31:0] w);
    tx_push = 1'b1; tx_data = w;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  // mode 0: normal, 1: TX underflow stall, 2: overfill TX before start
  task automatic run_burst(input int n, input int d, input int mode);
    int nw, fc, t;
    logic [31:0] w[$];
    logic [31:0] val;
    int vc;
    nw = (n + 31) / 32;
    fc = ((n - 1) % 32) + 1;
    cur_tag = (n % 32 == 1) ? "R6" : "R5";
    for (int i = 0; i < nw; i++) w.push_back($urandom);
    for (int b = fc - 1; b >= 0; b--) exp_mosi.push_back(w[0][b]);
    for (int i = 1; i < nw; i++)
      for (int b = 31; b >= 0; b--) exp_mosi.push_back(w[i][b]);
    for (int i = 0; i < n; i++) slv[i] = 1'($urandom);
    val = '0; vc = 0;
    for (int i = 0; i < n; i++) begin
      val = {val[30:0], slv[i]}; vc++;
      if (vc == 32 || i == n - 1) begin exp_rx.push_back(val); val = '0; vc = 0; end
    end
    base = tot_rise; cur_fc = fc; cur_div = d; chk_per = (mode != 1);
    if (mode == 1) push_tx(w[0]);
    else for (int i = 0; i < nw; i++) push_tx(w[i]);
    if (mode == 2) begin
      chk(tx_full, "R9", {31'd0, tx_full}, 32'd1);
      push_tx(32'hDEAD_BEEF);
    end
    burst_len = 12'(n - 1); clk_div = 8'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R2", {30'd0, cs_n, busy}, 32'd1);
    if (n >= 8) begin
      repeat (3) @(negedge clk);
      burst_len = 12'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (mode == 1) begin
      t = 0;
      while (tot_rise - base < fc && t < 20000) begin @(negedge clk); t++; end
      repeat (60) @(negedge clk);
      chk(!sclk && !cs_n && busy, "R7", {29'd0, sclk, cs_n, busy}, 32'd1);
      chk(tot_rise - base == fc, "R7", tot_rise - base, fc);
      for (int i = 1; i < nw; i++) push_tx(w[i]);
    end
    t = 0;
    while (!done && t < 50000) begin @(negedge clk); t++; end
    chk(done && cs_n && !busy, "R10", {29'd0, done, cs_n, busy}, 32'd6);
    @(negedge clk);
    chk(!done && cs_n, "R10", {30'd0, done, cs_n}, 32'd1);
    chk(tot_rise - base == n, "R4", tot_rise - base, n);
    chk(exp_mosi.size() == 0, cur_tag, exp_mosi.size(), 0);
    chk(tx_empty, "R9", {31'd0, tx_empty}, 32'd1);
    if (nw == 8) chk(rx_full, "R9", {31'd0, rx_full}, 32'd1);
    while (exp_rx.size() > 0) begin
      val = exp_rx.pop_front();
      chk(!rx_empty && rx_data == val, "R8", rx_data, val);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
    chk(rx_empty, "R9", {31'd0, rx_empty}, 32'd1);
    exp_mosi.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done, "R1", {28'd0, cs_n, sclk, busy, done}, 32'd8);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1",
        {28'd0, tx_empty, rx_empty, tx_full, rx_full}, 32'd12);
    rst_n = 1'b1;
    @(negedge clk);
    run_burst(40, 1, 0);
    run_burst(33, 0, 0);
    run_burst(65, 2, 0);
    run_burst(1, 0, 0);
    run_burst(32, 3, 0);
    run_burst(97, 1, 0);
    run_burst(17, 4, 0);
    run_burst(40, 1, 1);
    run_burst(256, 0, 2);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    chk(rx_empty && !rx_full, "R9", {30'd0, rx_empty, rx_full}, 32'd2);
    run_burst(3, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule